// File: doc/BRIEF.md
# Erase-then-Store CAM Slice

This block is a sixteen-entry content-addressable memory slice with an 8-bit key. Its match store is organised by key value: for each of the 256 possible keys it holds one bit per entry, and that bit is set when the entry currently holds that key. A search presents a key and, on the next rising clock edge, the registered 16-bit hit vector shows every entry holding that key. One search takes one clock cycle.

A write names an entry through a 4-bit address and supplies the new key on the same data input used for searches. It takes two clock cycles with the write enable held high. In the first cycle the bit for the entry's previous key is cleared; that key is found in a small per-entry shadow register. In the second cycle the bit for the new key is set and the shadow register takes the new key. A phase flag runs on the falling clock edge and chooses between the two steps.

The phase flag is forced to erase whenever the write enable is low and toggles on each falling edge while it is high. A one-cycle write therefore only erases the entry. A longer write alternates between erase and store. The hit register can be frozen with the search enable, or cleared synchronously through a separate active-low clear input.

Top module: `cam_slice`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the hit vector is 16'h0000, and no key matches any entry until that entry has been written.
- R2: With srch_en=1 and srch_clr_n=1 at a rising edge, hit_vec after that edge has bit i set exactly when entry i holds key_in.
- R3: A write with wr_en held high for two cycles stores key_in into entry wr_addr, so that a later search for that key sets bit wr_addr of hit_vec.
- R4: The first write cycle clears the bit for the key the entry held before, so that after a rewrite the old key no longer hits that entry.
- R5: A write with wr_en high for only one cycle erases the entry's old key and stores nothing, so neither the old nor the new key hits that entry.
- R6: While srch_en=0, hit_vec keeps its value whatever key_in, wr_en or wr_addr do.
- R7: With srch_en=1 and srch_clr_n=0 at a rising edge, hit_vec becomes 16'h0000.
- R8: A search in a cycle that also erases or stores returns the match contents from before that cycle's update.
- R9: Several entries may hold the same key and all of their bits are reported together; a write changes only the entry at wr_addr.
- R10: The phase flag is 0 (erase) whenever wr_en was low at the last falling edge and toggles at each falling edge while wr_en is high, so wr_en held for three cycles ends with the entry erased and held for four cycles ends with it stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage and hit register on the rising edge, phase flag on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| key_in | input | 8 | Search key, and the new key during a write |
| wr_addr | input | 4 | Entry written; ignored unless wr_en is high |
| wr_en | input | 1 | Write enable, held two cycles for a full write |
| srch_en | input | 1 | Lets the hit register update |
| srch_clr_n | input | 1 | Active-low synchronous clear of the hit register when srch_en is high |
| hit_vec | output | 16 | Registered match vector, bit i for entry i |

## Verification
A search and a write can land in the same cycle, because both use the single key input and both act on the rising edge. The bench holds srch_en high through both phases of a write and captures the hit vector after the erase edge and after the store edge. It expects the contents from before each update: the old set of matching entries after both edges, and the newly written entry only on a search made afterwards. One case writes a key that another entry already holds, so the pre-update vector is non-zero and a forwarding error would show up as an extra bit.

// File: rtl/cam_pkg.sv
// Package: cam_pkg
// Shared sizes and the write-phase type for the CAM slice.
// Assumes the slice is used at its default shape unless the top overrides it.
package cam_pkg;
    localparam int CAM_ENTRIES = 16;
    localparam int CAM_KEY_W   = 8;

    // Write phase: the first cycle of a write erases, the second stores.
    typedef enum logic {
        PH_ERASE = 1'b0,
        PH_STORE = 1'b1
    } wr_phase_t;
endpackage

// File: rtl/cam_wr_phase.sv
// Module: cam_wr_phase
// Produces the erase/store phase of a write. The flag lives on the falling
// edge so that the rising-edge storage sees a settled value. It is forced to
// erase while wr_en is low and toggles each falling edge while wr_en is high.
// Assumes rst_n is held low across at least one falling edge.
module cam_wr_phase
    import cam_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    output wr_phase_t phase
);

    // Falling-edge phase toggle with synchronous reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            phase <= PH_ERASE;
        end else if (!wr_en) begin
            phase <= PH_ERASE;
        end else begin
            phase <= (phase == PH_ERASE) ? PH_STORE : PH_ERASE;
        end
    end

    // R10: idle write enable returns the flag to erase.
    assert_phase_idle_R10: assert property (@(negedge clk) disable iff (!rst_n)
        !wr_en |=> phase == PH_ERASE);

    // R10: a held write enable flips the phase each falling edge.
    assert_phase_toggle_R10: assert property (@(negedge clk) disable iff (!rst_n)
        wr_en |=> phase != $past(phase));

endmodule

// File: rtl/cam_wr_decode.sv
// Module: cam_wr_decode
// Turns the write address into a one-hot entry select, gated by wr_en.
// Assumes ENTRIES is a power of two matching the address width.
module cam_wr_decode #(
    parameter int ENTRIES = 16,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    output logic [ENTRIES-1:0] wr_sel
);

    // One select line per entry, high only for the addressed entry.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    end

    // R9: at most one entry is touched by any write cycle.
    assert_one_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R9: a write always reaches exactly one entry.
    assert_write_reaches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $countones(wr_sel) == 1);

endmodule

// File: rtl/cam_entry_column.sv
// Module: cam_entry_column
// One CAM entry: a column of match bits, one per key value, plus a shadow
// register holding the key last stored. The erase step clears the bit named
// by the shadow, the store step sets the bit named by the key and refreshes
// the shadow. The hit output reads the column combinationally at the key,
// so a same-cycle search sees the column before this edge's update.
// Assumes sel is one-hot across columns and phase comes from cam_wr_phase.
module cam_entry_column
    import cam_pkg::*;
#(
    parameter int KEY_W = 8,
    localparam int ROWS = 1 << KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  wr_phase_t        phase,
    input  logic [KEY_W-1:0] key,
    output logic             hit
);

    logic [ROWS-1:0]  col;
    logic [KEY_W-1:0] shadow;
    logic             do_erase;
    logic             do_store;

    // Decode the write step for this entry.
    always_comb begin
        do_erase = sel && (phase == PH_ERASE);
        do_store = sel && (phase == PH_STORE);
    end

    // Match column: clear the old key's bit or set the new key's bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
        end else if (do_erase) begin
            col[shadow] <= 1'b0;
        end else if (do_store) begin
            col[key] <= 1'b1;
        end
    end

    // Shadow key, refreshed only when a new key is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (do_store) begin
            shadow <= key;
        end
    end

    // Search read of this entry's column at the presented key.
    always_comb begin
        hit = col[key];
    end

    // R4: after an erase the previously held key no longer matches.
    assert_erase_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_erase |=> !col[$past(shadow)]);

    // R3: after a store the new key matches and the shadow holds it.
    assert_store_new_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_store |=> (col[$past(key)] && shadow == $past(key)));

    // R9: an entry that is not selected keeps its column.
    assert_untouched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(col));

endmodule

// File: rtl/cam_slice.sv
// Module: cam_slice
// Top of the CAM slice: phase generator, write decoder, one column per entry,
// and the registered hit vector with hold and synchronous clear.
// Assumes key_in doubles as search key and write data.
module cam_slice
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int KEY_W   = CAM_KEY_W,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   key_in,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_en,
    input  logic               srch_en,
    input  logic               srch_clr_n,
    output logic [ENTRIES-1:0] hit_vec
);

    wr_phase_t          phase;
    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] row_hit;

    cam_wr_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .phase (phase)
    );

    cam_wr_decode #(.ENTRIES(ENTRIES)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        cam_entry_column #(.KEY_W(KEY_W)) u_col (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (wr_sel[g]),
            .phase (phase),
            .key   (key_in),
            .hit   (row_hit[g])
        );
    end

    // Hit register: clear, capture or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec <= '0;
        end else if (srch_en) begin
            hit_vec <= srch_clr_n ? row_hit : '0;
        end
    end

    // R1: the first cycle out of reset shows no hits.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> hit_vec == '0);

    // R2 and R8: a search reports the columns as they were before the edge.
    assert_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && srch_clr_n) |=> hit_vec == $past(row_hit));

    // R6: the hit register holds while searching is disabled.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> $stable(hit_vec));

    // R7: the synchronous clear empties the hit register.
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && !srch_clr_n) |=> hit_vec == '0);

endmodule

// File: tb/tb_cam_slice.sv
// Directed bench for cam_slice. Inputs change 1 ns after a falling edge,
// outputs are read 1 ns after a rising edge.
module tb_cam_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  key_in = '0;
    logic [3:0]  wr_addr = '0;
    logic        wr_en = 1'b0;
    logic        srch_en = 1'b0;
    logic        srch_clr_n = 1'b1;
    logic [15:0] hit_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    cam_slice dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_in     (key_in),
        .wr_addr    (wr_addr),
        .wr_en      (wr_en),
        .srch_en    (srch_en),
        .srch_clr_n (srch_clr_n),
        .hit_vec    (hit_vec)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b0; srch_en = 1'b0; srch_clr_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Write holding wr_en for n cycles.
    task automatic wr(input logic [3:0] a, input logic [7:0] v, input int n);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; key_in = v; srch_en = 1'b0;
        repeat (n) @(negedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic srch(input logic [7:0] k, output logic [15:0] h);
        @(negedge clk); #1;
        key_in = k; srch_en = 1'b1; srch_clr_n = 1'b1;
        @(posedge clk); #1 h = hit_vec;
        @(negedge clk); #1 srch_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] h;
        do_reset();
        @(posedge clk); #1 check("R1 reset value", hit_vec, 16'h0000);
        srch(8'h00, h); check("R1 empty key 00", h, 16'h0000);
        srch(8'hA5, h); check("R1 empty key A5", h, 16'h0000);
    endtask

    task automatic t_write_basic();
        logic [15:0] h;
        wr(4'd3, 8'hA5, 2);
        srch(8'hA5, h); check("R3 store entry 3", h, 16'h0008);
        srch(8'h5A, h); check("R2 other key misses", h, 16'h0000);
    endtask

    task automatic t_shared_key();
        logic [15:0] h;
        wr(4'd7, 8'hA5, 2);
        srch(8'hA5, h); check("R9 two entries share key", h, 16'h0088);
        wr(4'd12, 8'h3C, 2);
        srch(8'h3C, h); check("R3 store entry 12", h, 16'h1000);
        srch(8'hA5, h); check("R9 others untouched", h, 16'h0088);
    endtask

    task automatic t_rewrite();
        logic [15:0] h;
        wr(4'd3, 8'h11, 2);
        srch(8'hA5, h); check("R4 old key erased", h, 16'h0080);
        srch(8'h11, h); check("R3 new key stored", h, 16'h0008);
    endtask

    task automatic t_short_write();
        logic [15:0] h;
        wr(4'd7, 8'h22, 1);
        srch(8'hA5, h); check("R5 short write erases", h, 16'h0000);
        srch(8'h22, h); check("R5 short write stores nothing", h, 16'h0000);
    endtask

    task automatic t_hold();
        logic [15:0] h;
        srch(8'h3C, h); check("R2 search before hold", h, 16'h1000);
        @(negedge clk); #1 key_in = 8'h11; srch_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 check("R6 hold with new key", hit_vec, 16'h1000);
        wr(4'd0, 8'h3C, 2);
        @(posedge clk); #1 check("R6 hold across write", hit_vec, 16'h1000);
        srch(8'h3C, h); check("R3 entry 0 stored", h, 16'h1001);
    endtask

    task automatic t_clear();
        logic [15:0] h;
        @(negedge clk); #1 key_in = 8'h3C; srch_en = 1'b1; srch_clr_n = 1'b0;
        @(posedge clk); #1 check("R7 clear", hit_vec, 16'h0000);
        @(negedge clk); #1 srch_en = 1'b0; srch_clr_n = 1'b1;
        srch(8'h3C, h); check("R7 contents survive clear", h, 16'h1001);
    endtask

    task automatic t_concurrent();
        logic [15:0] h1, h2, h;
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'd3; key_in = 8'h3C; srch_en = 1'b1; srch_clr_n = 1'b1;
        @(posedge clk); #1 h1 = hit_vec;
        @(posedge clk); #1 h2 = hit_vec;
        @(negedge clk); #1 wr_en = 1'b0; srch_en = 1'b0;
        check("R8 search at erase edge", h1, 16'h1001);
        check("R8 search at store edge", h2, 16'h1001);
        srch(8'h3C, h); check("R8 visible afterwards", h, 16'h1009);
        srch(8'h11, h); check("R4 entry 3 old key gone", h, 16'h0000);
    endtask

    task automatic t_long_writes();
        logic [15:0] h;
        wr(4'd9, 8'h77, 3);
        srch(8'h77, h); check("R10 three cycles end erased", h, 16'h0000);
        wr(4'd9, 8'h66, 4);
        srch(8'h66, h); check("R10 four cycles end stored", h, 16'h0200);
    endtask

    task automatic t_reset_again();
        logic [15:0] h;
        do_reset();
        srch(8'h3C, h); check("R1 contents cleared by reset", h, 16'h0000);
        srch(8'h66, h); check("R1 entry 9 cleared by reset", h, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_write_basic();
        t_shared_key();
        t_rewrite();
        t_short_write();
        t_hold();
        t_clear();
        t_concurrent();
        t_long_writes();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule